// File: doc/BRIEF.md
# Multifunction Pin Group Mux

This block holds the role setting of eleven multifunction pins and decides, from those settings, which pins are handed to a multi-pin peripheral. Each pin has a 4-bit role register, written through a simple register write port at consecutive addresses starting at 0x19 (pin 0) up to 0x23 (pin 10). A role picks general-purpose digital input or output, an analog function, an ADC input, or a dedicated peripheral role.

Pins 0 to 5 form the SIM level-shifter group, with reset, clock and data on the host side as pins 0 to 2 and on the card side as pins 3 to 5. Pins 6 to 10 serve the USB transceiver: output enable (6), data or plus line (7), single-ended-zero or minus line (8), receive (9) and suspend (10). A peripheral is attached only when every pin of its group carries that peripheral's role. A pin that asks for a peripheral role whose group is incomplete is parked, not attached. Separate shutdown inputs switch a connected peripheral off without detaching it from its pins.

Top module: `mfp_pin_mux`

## Requirements
- R1: After reset every pin role code is 0 (digital input), every pin route is 0 and every connect and active output is 0.
- R2: A write with wrEn high to address 0x19+k, where k is 0 to 10, stores wrData into pin k's role code, and the new code appears on pinCfg bits [4k+3:4k] in the cycle after the write edge.
- R3: A write to an address below 0x19 or above 0x23, or any cycle with wrEn low, leaves every role code unchanged.
- R4: For role codes below 8, pinRoute field k (bits [3k+2:3k]) is 0 for code 0 (digital input), 1 for code 1 (digital output), 2 for code 2 (analog), 3 for code 3 (ADC input), and 0 for the reserved codes 4 to 7.
- R5: simConnect is 1 exactly when pins 0 to 5 all hold role code 8 (level shifter).
- R6: usb3Connect is 1 exactly when pins 6, 7 and 8 all hold role code 9 (3-wire USB).
- R7: usb5Connect is 1 exactly when pins 6 to 9 all hold role code 10 (5-wire USB), and usbSuspLinked is 1 exactly when usb5Connect is 1 and pin 10 also holds code 10.
- R8: A pin holding a code of 8 or above routes as 4 (attached) when that code is its group's role and the matching connect output is 1, and as 5 (parked) in every other case, including codes that no peripheral on that pin uses.
- R9: simActive equals simConnect with simShutdown low, and usbActive equals (usb3Connect or usb5Connect) with usbShutdown low. The shutdown inputs change neither the connect outputs nor pinRoute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 4 | Role code to write |
| simShutdown | input | 1 | Shuts the SIM level shifter down |
| usbShutdown | input | 1 | Shuts the USB transceiver down |
| pinCfg | output | 44 | Stored role code of each pin, 4 bits per pin |
| pinRoute | output | 33 | Resolved route of each pin, 3 bits per pin |
| simConnect | output | 1 | SIM level shifter attached to its pins |
| usb3Connect | output | 1 | USB attached in 3-wire mode |
| usb5Connect | output | 1 | USB attached in 4/5-wire mode |
| usbSuspLinked | output | 1 | Suspend pin attached as well (5-wire link) |
| simActive | output | 1 | SIM level shifter attached and running |
| usbActive | output | 1 | USB attached and running |

## Verification
The hardest condition to reach from the ports is a group that is one pin short of complete, or one that was complete and is broken by a single rewrite. In that state the other pins of the group must show as parked while the odd pin keeps its own route. The stimulus table builds each group one write at a time and checks the connect outputs after every write. It then breaks a finished group by rewriting one member, rebuilds it, and in the same way leaves the suspend pin holding its 5-wire role after the rest of the USB group is gone.

// File: rtl/mfp_pkg.sv
package mfp_pkg;

  localparam int NUM_PINS = 11;
  localparam int ROLE_W   = 4;
  localparam int ROUTE_W  = 3;

  // role codes held per pin
  localparam logic [ROLE_W-1:0] ROLE_GPIN   = 4'h0;
  localparam logic [ROLE_W-1:0] ROLE_GPOUT  = 4'h1;
  localparam logic [ROLE_W-1:0] ROLE_ANALOG = 4'h2;
  localparam logic [ROLE_W-1:0] ROLE_ADC    = 4'h3;
  localparam logic [ROLE_W-1:0] ROLE_SIM    = 4'h8;
  localparam logic [ROLE_W-1:0] ROLE_USB3   = 4'h9;
  localparam logic [ROLE_W-1:0] ROLE_USB5   = 4'hA;

  // group membership masks, bit k = pin k
  localparam logic [NUM_PINS-1:0] SIM_MASK  = 11'b000_0011_1111;
  localparam logic [NUM_PINS-1:0] USB3_MASK = 11'b001_1100_0000;
  localparam logic [NUM_PINS-1:0] USB5_MASK = 11'b011_1100_0000;
  localparam int                  SUSP_PIN  = 10;

  typedef enum logic [ROUTE_W-1:0] {
    ROUTE_GPIN   = 3'd0,
    ROUTE_GPOUT  = 3'd1,
    ROUTE_ANALOG = 3'd2,
    ROUTE_ADC    = 3'd3,
    ROUTE_LINK   = 3'd4,
    ROUTE_PARKED = 3'd5
  } route_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_PINS-1:0] pinWe;
    logic [ROLE_W-1:0]   role;
  } cfg_strobe_t;

endpackage

// File: rtl/mfp_ctrl.sv
module mfp_ctrl
  import mfp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ADDR_BASE = 'h19
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ROLE_W-1:0] wrData,
  output cfg_strobe_t       stb
);

  logic [NUM_PINS-1:0] hit;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_dec
    localparam logic [ADDR_W-1:0] PIN_ADDR = ADDR_W'(ADDR_BASE + k);
    assign hit[k] = (wrAddr == PIN_ADDR);
  end

  always_comb begin
    stb.pinWe = wrEn ? hit : '0;
    stb.role  = wrData;
  end

endmodule

// File: rtl/mfp_datapath.sv
module mfp_datapath
  import mfp_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  cfg_strobe_t                 stb,
  input  logic                        simShutdown,
  input  logic                        usbShutdown,
  output logic [NUM_PINS*ROLE_W-1:0]  pinCfg,
  output logic [NUM_PINS*ROUTE_W-1:0] pinRoute,
  output logic                        simConnect,
  output logic                        usb3Connect,
  output logic                        usb5Connect,
  output logic                        usbSuspLinked,
  output logic                        simActive,
  output logic                        usbActive
);

  logic [ROLE_W-1:0]   cfgQ [NUM_PINS];
  logic [NUM_PINS-1:0] isSim, isUsb3, isUsb5;
  route_e              route [NUM_PINS];

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              cfgQ[k] <= ROLE_GPIN;
      else if (stb.pinWe[k])  cfgQ[k] <= stb.role;
    end

    assign isSim[k]  = (cfgQ[k] == ROLE_SIM);
    assign isUsb3[k] = (cfgQ[k] == ROLE_USB3);
    assign isUsb5[k] = (cfgQ[k] == ROLE_USB5);

    always_comb begin
      if (!cfgQ[k][ROLE_W-1]) begin
        unique case (cfgQ[k][1:0])
          2'd0:    route[k] = ROUTE_GPIN;
          2'd1:    route[k] = (cfgQ[k][2]) ? ROUTE_GPIN : ROUTE_GPOUT;
          2'd2:    route[k] = (cfgQ[k][2]) ? ROUTE_GPIN : ROUTE_ANALOG;
          default: route[k] = (cfgQ[k][2]) ? ROUTE_GPIN : ROUTE_ADC;
        endcase
      end else if ((isSim[k] && SIM_MASK[k] && simConnect) ||
                   (isUsb3[k] && USB3_MASK[k] && usb3Connect) ||
                   (isUsb5[k] && USB5_MASK[k] && usb5Connect) ||
                   (isUsb5[k] && (k == SUSP_PIN) && usbSuspLinked)) begin
        route[k] = ROUTE_LINK;
      end else begin
        route[k] = ROUTE_PARKED;
      end
    end

    assign pinCfg[k*ROLE_W +: ROLE_W]     = cfgQ[k];
    assign pinRoute[k*ROUTE_W +: ROUTE_W] = route[k];

    // R8: attached group pins report the attached route
    if (SIM_MASK[k]) begin : g_simchk
      a_r8_sim_pin_linked: assert property (@(posedge clk) disable iff (!rstN)
        simConnect |-> pinRoute[k*ROUTE_W +: ROUTE_W] == ROUTE_LINK);
    end
  end

  // all pins of a group must match its role
  assign simConnect    = &(isSim  | ~SIM_MASK);
  assign usb3Connect   = &(isUsb3 | ~USB3_MASK);
  assign usb5Connect   = &(isUsb5 | ~USB5_MASK);
  assign usbSuspLinked = usb5Connect & isUsb5[SUSP_PIN];

  assign simActive = simConnect & ~simShutdown;
  assign usbActive = (usb3Connect | usb5Connect) & ~usbShutdown;

  a_r9_sim_active_needs_link: assert property (@(posedge clk) disable iff (!rstN)
    simActive |-> (simConnect && !simShutdown));
  a_r9_usb_shutdown_off: assert property (@(posedge clk) disable iff (!rstN)
    usbShutdown |-> !usbActive);
  a_r7_susp_needs_wide: assert property (@(posedge clk) disable iff (!rstN)
    usbSuspLinked |-> usb5Connect);
  a_r5_sim_only_by_write: assert property (@(posedge clk) disable iff (!rstN)
    !$past(|stb.pinWe) |-> $stable(simConnect));

endmodule

// File: rtl/mfp_pin_mux.sv
module mfp_pin_mux
  import mfp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ADDR_BASE = 'h19
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [ROLE_W-1:0]           wrData,
  input  logic                        simShutdown,
  input  logic                        usbShutdown,
  output logic [NUM_PINS*ROLE_W-1:0]  pinCfg,
  output logic [NUM_PINS*ROUTE_W-1:0] pinRoute,
  output logic                        simConnect,
  output logic                        usb3Connect,
  output logic                        usb5Connect,
  output logic                        usbSuspLinked,
  output logic                        simActive,
  output logic                        usbActive
);

  cfg_strobe_t stb;

  mfp_ctrl #(.ADDR_W(ADDR_W), .ADDR_BASE(ADDR_BASE)) i_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .stb    (stb)
  );

  mfp_datapath i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .simShutdown   (simShutdown),
    .usbShutdown   (usbShutdown),
    .pinCfg        (pinCfg),
    .pinRoute      (pinRoute),
    .simConnect    (simConnect),
    .usb3Connect   (usb3Connect),
    .usb5Connect   (usb5Connect),
    .usbSuspLinked (usbSuspLinked),
    .simActive     (simActive),
    .usbActive     (usbActive)
  );

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_wrchk
    localparam logic [ADDR_W-1:0] PIN_ADDR = ADDR_W'(ADDR_BASE + k);
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == PIN_ADDR) |=> pinCfg[k*ROLE_W +: ROLE_W] == $past(wrData));
  end

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(pinCfg));

endmodule

// File: tb/test_mfp_pin_mux.sv
module test_mfp_pin_mux;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [3:0]  wrData = '0;
  logic        simShutdown = 1'b0;
  logic        usbShutdown = 1'b0;
  logic [43:0] pinCfg;
  logic [32:0] pinRoute;
  logic        simConnect, usb3Connect, usb5Connect, usbSuspLinked;
  logic        simActive, usbActive;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mfp_pin_mux i_mfp_pin_mux (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .simShutdown(simShutdown), .usbShutdown(usbShutdown),
    .pinCfg(pinCfg), .pinRoute(pinRoute),
    .simConnect(simConnect), .usb3Connect(usb3Connect),
    .usb5Connect(usb5Connect), .usbSuspLinked(usbSuspLinked),
    .simActive(simActive), .usbActive(usbActive)
  );

  // {addr, data, expSim, expUsb3, expUsb5, expSusp}
  localparam logic [15:0] VEC [16] = '{
    {8'h19, 4'h8, 4'b0000}, {8'h1A, 4'h8, 4'b0000}, {8'h1B, 4'h8, 4'b0000},
    {8'h1C, 4'h8, 4'b0000}, {8'h1D, 4'h8, 4'b0000}, {8'h1E, 4'h8, 4'b1000},
    {8'h1F, 4'h9, 4'b1000}, {8'h20, 4'h9, 4'b1000}, {8'h21, 4'h9, 4'b1100},
    {8'h1B, 4'h2, 4'b0100}, {8'h1F, 4'hA, 4'b0000}, {8'h20, 4'hA, 4'b0000},
    {8'h21, 4'hA, 4'b0000}, {8'h22, 4'hA, 4'b0010}, {8'h23, 4'hA, 4'b0011},
    {8'h1B, 4'h8, 4'b1011}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [3:0] d, input logic en);
    @(negedge clk);
    wrEn = en; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [32:0] allRoutes(input logic [2:0] r);
    logic [32:0] v;
    for (int k = 0; k < 11; k++) v[k*3 +: 3] = r;
    return v;
  endfunction

  function automatic logic [3:0] flags();
    return {simConnect, usb3Connect, usb5Connect, usbSuspLinked};
  endfunction

  logic [43:0] cfgSnap;
  logic [32:0] expRoute;

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pinCfg == '0 && pinRoute == '0, "R1 reset cfg/route", {pinCfg, pinRoute[19:0]}, 0);
    check(flags() == 4'b0 && !simActive && !usbActive, "R1 reset connects",
          {flags(), simActive, usbActive}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R5 R6 R7: cumulative group build-up
    for (int i = 0; i < 16; i++) begin
      doWrite(VEC[i][15:8], VEC[i][7:4], 1'b1);
      check(pinCfg[(VEC[i][15:8]-8'h19)*4 +: 4] == VEC[i][7:4], "R2 write lands",
            pinCfg[(VEC[i][15:8]-8'h19)*4 +: 4], VEC[i][7:4]);
      check(flags() == VEC[i][3:0], "R5 R6 R7 connect flags", flags(), VEC[i][3:0]);
    end

    // R8 every pin attached
    check(pinRoute == allRoutes(3'd4), "R8 all linked", pinRoute, allRoutes(3'd4));

    // R9 shutdown does not detach
    simShutdown = 1'b1;
    @(negedge clk);
    check(!simActive && simConnect && pinRoute == allRoutes(3'd4), "R9 sim shutdown",
          {simActive, simConnect}, 2'b01);
    check(usbActive, "R9 usb still active", usbActive, 1);
    usbShutdown = 1'b1; simShutdown = 1'b0;
    @(negedge clk);
    check(!usbActive && usb5Connect && simActive && pinRoute == allRoutes(3'd4),
          "R9 usb shutdown", {usbActive, usb5Connect, simActive}, 3'b011);
    usbShutdown = 1'b0;

    // R3 out-of-range and disabled writes
    cfgSnap = pinCfg;
    doWrite(8'h18, 4'h1, 1'b1);
    doWrite(8'h24, 4'h1, 1'b1);
    doWrite(8'h19, 4'h1, 1'b0);
    check(pinCfg == cfgSnap && flags() == 4'b1011, "R3 ignored writes", pinCfg, cfgSnap);

    // R4 R8: pin 0 leaves SIM role, sim pins 1..5 park
    doWrite(8'h19, 4'h1, 1'b1);
    expRoute = allRoutes(3'd4);
    for (int k = 0; k < 6; k++) expRoute[k*3 +: 3] = 3'd5;
    expRoute[2:0] = 3'd1;
    check(pinRoute == expRoute && !simConnect, "R4 R8 gpio out, sim parked", pinRoute, expRoute);
    doWrite(8'h19, 4'h3, 1'b1);
    check(pinRoute[2:0] == 3'd3, "R4 adc", pinRoute[2:0], 3);
    doWrite(8'h19, 4'h6, 1'b1);
    check(pinRoute[2:0] == 3'd0, "R4 reserved as input", pinRoute[2:0], 0);
    doWrite(8'h19, 4'h2, 1'b1);
    check(pinRoute[2:0] == 3'd2, "R4 analog", pinRoute[2:0], 2);
    doWrite(8'h19, 4'hB, 1'b1);
    check(pinRoute[2:0] == 3'd5, "R8 unused code parks", pinRoute[2:0], 5);

    // R7 R8: USB group broken, suspend pin parks
    doWrite(8'h22, 4'h0, 1'b1);
    check(flags() == 4'b0000 && !usbActive, "R7 wide broken", flags(), 0);
    check(pinRoute[32:30] == 3'd5 && pinRoute[29:27] == 3'd0 && pinRoute[26:18] == {3{3'd5}},
          "R8 usb pins parked", pinRoute[32:18], 15'o50555);
    // R6 3-wire role on the suspend pin does nothing
    doWrite(8'h23, 4'h9, 1'b1);
    check(pinRoute[32:30] == 3'd5 && !usb3Connect, "R6 suspend pin has no 3-wire role",
          pinRoute[32:30], 5);

    // R1 reset clears everything again
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(pinCfg == '0 && flags() == 4'b0 && pinRoute == '0, "R1 re-reset", pinCfg, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule